// File: doc/BRIEF.md
# Dual-Lane SIMD Fixed-Point Datapath

This block is the execute stage of a signal-processing core. It has two identical 32-bit fixed-point lanes, X and Y, fed by a single instruction stream. Each lane has an adder/logic unit, a multiplier, a barrel shifter, its own zero and negative flags, and its own register file. The register file holds two banks of sixteen registers, primary and secondary.

Lane X always runs. Lane Y runs only when the lane-enable mode bit is set. When it is set, the decoded instruction acts in both lanes in the same cycle, each lane on its own register contents. Loads and stores then move two words per access over the 64-bit memory data path.

A small mode state machine samples the two-bit mode input on every clock. It has four states:
- MS_SX_PRI: single lane, primary bank.
- MS_DU_PRI: both lanes, primary bank.
- MS_SX_SEC: single lane, secondary bank.
- MS_DU_SEC: both lanes, secondary bank.

On every clock edge the machine moves from any state to the state named by `mode_i`. The four transitions into each target state are: mode 00 to MS_SX_PRI, 01 to MS_DU_PRI, 10 to MS_SX_SEC and 11 to MS_DU_SEC. Reset enters MS_SX_PRI. An instruction always uses the state that was in place before its own issue cycle.

Top module: `simd_datapath`

## Requirements
- R1: After reset, every register in both banks of both lanes reads zero. All flags, `wb_valid_o`, `st_valid_o` and `st_wide_o` are low. The mode state is MS_SX_PRI.
- R2: The instruction word is 21 bits wide, with these fields:
  - [20:17] opcode
  - [16:13] destination index
  - [12:9] source A index
  - [8:5] source B index
  - [4] multifunction flag
  - [3:0] second destination index

  The opcodes are:
  - 1: add
  - 2: subtract (A minus B)
  - 3: AND
  - 4: OR
  - 5: XOR
  - 6: multiply
  - 7: shift left
  - 8: arithmetic shift right
  - 9: load
  - 10: store
  - 0 and 11 to 15: no operation

  Add and subtract wrap modulo 2^32.
- R3: Multiply writes the low 32 bits of the signed 32x32 product of A and B.
- R4: Shift left is logical. Arithmetic shift right copies the sign bit. Both shift by source B bits [4:0].
- R5: Every operation completes in one cycle. Its result is on `wb_data_o`, with `wb_valid_o` set, in the cycle after issue. The next instruction can already read that result as a source.
- R6: With lane Y enabled, both lanes execute the same instruction in the same cycle, each on its own register file. `wb_data_o[63:32]` carries lane Y and `wb_data_o[31:0]` carries lane X.
- R7: With lane Y disabled, lane Y writes no register and updates no flag, and `wb_valid_o[1]` stays low.
- R8: A load writes `ld_data_i[31:0]` into lane X and `ld_data_i[63:32]` into lane Y. With lane Y disabled, the upper half is ignored.
- R9: A store sets `st_valid_o` one cycle after issue, with source A of lane X on `st_data_o[31:0]` and of lane Y on `st_data_o[63:32]`. `st_wide_o` is 1 when lane Y is enabled. With lane Y disabled, the upper half is zero.
- R10: A multifunction instruction is an add-to-XOR opcode with bit 4 set. It also writes the product A*B into the second destination. If both destinations are the same register, the product wins.
- R11: Mode bit 1 selects the secondary bank and mode bit 0 enables lane Y. The two banks hold independent contents.
- R12: A mode change applies from the instruction after the one issued in the same cycle as the change. That instruction itself still uses the previous mode.
- R13: The zero and negative flags of each lane are updated only by the add-to-XOR opcodes. Multiply, shift, load and store leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction issue strobe |
| instr_i | input | 21 | Instruction word |
| mode_i | input | 2 | Bit 0 lane Y enable, bit 1 secondary bank |
| ld_data_i | input | 64 | Load data, lane Y upper half |
| wb_valid_o | output | 2 | Per-lane writeback strobe, bit 1 = lane Y |
| wb_data_o | output | 64 | Per-lane writeback result |
| st_valid_o | output | 1 | Store data valid |
| st_wide_o | output | 1 | Store moved two words |
| st_data_o | output | 64 | Store data, lane Y upper half |
| flag_zero_o | output | 2 | Per-lane zero flag |
| flag_neg_o | output | 2 | Per-lane negative flag |

## Verification
The hardest state to reach is the content of lane Y's registers and flags while the lane is off. It is invisible at the ports until the lane is switched back on. The bench issues loads in single-lane mode with non-zero upper halves, then moves to dual mode and stores the same registers to show they were never written. A second hard case is changing the mode bits in the same cycle as an instruction issues. The bench drives the mode and the instruction together, then checks that instruction and the next one for the old and new lane and bank behaviour.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int INSTR_W = 21;
    localparam int IDX_W   = 4;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_MUL   = 4'd6,
        OP_SHL   = 4'd7,
        OP_ASR   = 4'd8,
        OP_LOAD  = 4'd9,
        OP_STORE = 4'd10
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic             mf;
        logic [IDX_W-1:0] mdst;
    } instr_t;

    // Encoding of the state equals {bank, lane_y_enable} of the mode input.
    typedef enum logic [1:0] {
        MS_SX_PRI = 2'b00,
        MS_DU_PRI = 2'b01,
        MS_SX_SEC = 2'b10,
        MS_DU_SEC = 2'b11
    } mode_state_e;

    function automatic logic op_is_alu(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_XOR);
    endfunction

    function automatic logic op_writes(input op_e op);
        return op_is_alu(op) || (op == OP_MUL) || (op == OP_SHL) ||
               (op == OP_ASR) || (op == OP_LOAD);
    endfunction

endpackage

// File: rtl/simd_mode_fsm.sv
module simd_mode_fsm
    import simd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    output logic       y_en_o,
    output logic       bank_o
);

    mode_state_e state_q;
    mode_state_e state_d;

    always_comb begin
        unique case (mode_i)
            2'b00:   state_d = MS_SX_PRI;
            2'b01:   state_d = MS_DU_PRI;
            2'b10:   state_d = MS_SX_SEC;
            default: state_d = MS_DU_SEC;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= MS_SX_PRI;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            MS_SX_PRI: begin y_en_o = 1'b0; bank_o = 1'b0; end
            MS_DU_PRI: begin y_en_o = 1'b1; bank_o = 1'b0; end
            MS_SX_SEC: begin y_en_o = 1'b0; bank_o = 1'b1; end
            default:   begin y_en_o = 1'b1; bank_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/simd_regfile.sv
module simd_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_ARCH = 16
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        bank_i,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_a_idx_i,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_b_idx_i,
    output logic [DATA_W-1:0]           rd_a_o,
    output logic [DATA_W-1:0]           rd_b_o,
    input  logic                        we0_i,
    input  logic [$clog2(NUM_ARCH)-1:0] wa0_i,
    input  logic [DATA_W-1:0]           wd0_i,
    input  logic                        we1_i,
    input  logic [$clog2(NUM_ARCH)-1:0] wa1_i,
    input  logic [DATA_W-1:0]           wd1_i
);

    localparam int IW    = $clog2(NUM_ARCH);
    localparam int DEPTH = 2 * NUM_ARCH;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_a_o = mem_q[{bank_i, rd_a_idx_i}];
    assign rd_b_o = mem_q[{bank_i, rd_b_idx_i}];

    // Port 1 is written last so it wins on an address clash.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (we0_i) begin
                mem_q[{bank_i, wa0_i[IW-1:0]}] <= wd0_i;
            end
            if (we1_i) begin
                mem_q[{bank_i, wa1_i[IW-1:0]}] <= wd1_i;
            end
        end
    end

endmodule

// File: rtl/simd_exec.sv
module simd_exec
    import simd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] ld_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] prod_o
);

    localparam int SH_W = $clog2(DATA_W);

    logic [2*DATA_W-1:0] full_prod;
    logic [SH_W-1:0]     sh_amt;

    assign full_prod = $signed(a_i) * $signed(b_i);
    assign prod_o    = full_prod[DATA_W-1:0];
    assign sh_amt    = b_i[SH_W-1:0];

    always_comb begin
        unique case (op_i)
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_MUL:  res_o = prod_o;
            OP_SHL:  res_o = a_i << sh_amt;
            OP_ASR:  res_o = $unsigned($signed(a_i) >>> sh_amt);
            OP_LOAD: res_o = ld_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_ARCH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              bank_i,
    input  logic              valid_i,
    input  instr_t            instr_i,
    input  logic [DATA_W-1:0] ld_word_i,
    output logic              wb_valid_o,
    output logic [DATA_W-1:0] wb_data_o,
    output logic [DATA_W-1:0] st_word_o,
    output logic              zero_o,
    output logic              neg_o
);

    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] prod;
    logic              go;
    logic              wr_main;
    logic              wr_prod;
    logic              upd_flags;

    assign go        = valid_i && en_i;
    assign wr_main   = go && op_writes(instr_i.op);
    assign upd_flags = go && op_is_alu(instr_i.op);
    assign wr_prod   = upd_flags && instr_i.mf;

    simd_regfile #(
        .DATA_W   (DATA_W),
        .NUM_ARCH (NUM_ARCH)
    ) u_rf (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bank_i     (bank_i),
        .rd_a_idx_i (instr_i.src_a),
        .rd_b_idx_i (instr_i.src_b),
        .rd_a_o     (rd_a),
        .rd_b_o     (rd_b),
        .we0_i      (wr_main),
        .wa0_i      (instr_i.dst),
        .wd0_i      (res),
        .we1_i      (wr_prod),
        .wa1_i      (instr_i.mdst),
        .wd1_i      (prod)
    );

    simd_exec #(
        .DATA_W (DATA_W)
    ) u_exec (
        .op_i   (instr_i.op),
        .a_i    (rd_a),
        .b_i    (rd_b),
        .ld_i   (ld_word_i),
        .res_o  (res),
        .prod_o (prod)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            zero_o <= 1'b0;
            neg_o  <= 1'b0;
        end else if (upd_flags) begin
            zero_o <= (res == '0);
            neg_o  <= res[DATA_W-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wb_valid_o <= 1'b0;
            wb_data_o  <= '0;
        end else begin
            wb_valid_o <= wr_main;
            if (wr_main) begin
                wb_data_o <= res;
            end
        end
    end

    assign st_word_o = en_i ? rd_a : '0;

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
    import simd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_ARCH = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  instr_valid_i,
    input  logic [INSTR_W-1:0]    instr_i,
    input  logic [1:0]            mode_i,
    input  logic [2*DATA_W-1:0]   ld_data_i,
    output logic [1:0]            wb_valid_o,
    output logic [2*DATA_W-1:0]   wb_data_o,
    output logic                  st_valid_o,
    output logic                  st_wide_o,
    output logic [2*DATA_W-1:0]   st_data_o,
    output logic [1:0]            flag_zero_o,
    output logic [1:0]            flag_neg_o
);

    localparam int NUM_LANES = 2;

    instr_t                       ins;
    logic                         y_en;
    logic                         bank;
    logic [NUM_LANES-1:0]         lane_en;
    logic [NUM_LANES*DATA_W-1:0]  st_words;
    logic                         is_store;

    assign ins      = instr_t'(instr_i);
    assign is_store = instr_valid_i && (ins.op == OP_STORE);

    simd_mode_fsm u_mode (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (mode_i),
        .y_en_o (y_en),
        .bank_o (bank)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        if (g == 0) begin : g_always
            assign lane_en[g] = 1'b1;
        end else begin : g_gated
            assign lane_en[g] = y_en;
        end

        simd_lane #(
            .DATA_W   (DATA_W),
            .NUM_ARCH (NUM_ARCH)
        ) u_lane (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .en_i       (lane_en[g]),
            .bank_i     (bank),
            .valid_i    (instr_valid_i),
            .instr_i    (ins),
            .ld_word_i  (ld_data_i[g*DATA_W +: DATA_W]),
            .wb_valid_o (wb_valid_o[g]),
            .wb_data_o  (wb_data_o[g*DATA_W +: DATA_W]),
            .st_word_o  (st_words[g*DATA_W +: DATA_W]),
            .zero_o     (flag_zero_o[g]),
            .neg_o      (flag_neg_o[g])
        );
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_valid_o <= 1'b0;
            st_wide_o  <= 1'b0;
            st_data_o  <= '0;
        end else begin
            st_valid_o <= is_store;
            if (is_store) begin
                st_wide_o <= y_en;
                st_data_o <= st_words;
            end
        end
    end

endmodule

// File: rtl/simd_datapath_chk.sv
module simd_datapath_chk
    import simd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                instr_valid_i,
    input logic [INSTR_W-1:0]  instr_i,
    input logic                y_en,
    input logic [1:0]          wb_valid_o,
    input logic                st_valid_o,
    input logic                st_wide_o,
    input logic [2*DATA_W-1:0] st_data_o,
    input logic [1:0]          flag_zero_o,
    input logic [1:0]          flag_neg_o
);

    instr_t ci;
    assign ci = instr_t'(instr_i);

    AST_Y_OFF_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !y_en) |=> !wb_valid_o[1]); // R7

    AST_Y_OFF_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !y_en) |=> ($stable(flag_zero_o[1]) && $stable(flag_neg_o[1]))); // R7

    AST_NARROW_STORE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_valid_o && !st_wide_o) |-> (st_data_o[2*DATA_W-1:DATA_W] == '0)); // R9

    AST_STORE_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && ci.op == OP_STORE) |=> st_valid_o); // R5

    AST_WRITE_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && op_writes(ci.op)) |=> wb_valid_o[0]); // R5

    AST_IDLE_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_valid_i |=> (wb_valid_o == 2'b00)); // R5

    AST_Y_WB_WITH_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_valid_o[1] |-> wb_valid_o[0]); // R6

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flag_zero_o & flag_neg_o) == 2'b00)); // R13

    AST_NON_ALU_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(instr_valid_i && op_is_alu(ci.op)) |=> ($stable(flag_zero_o) && $stable(flag_neg_o))); // R13

endmodule

bind simd_datapath simd_datapath_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .y_en          (y_en),
    .wb_valid_o    (wb_valid_o),
    .st_valid_o    (st_valid_o),
    .st_wide_o     (st_wide_o),
    .st_data_o     (st_data_o),
    .flag_zero_o   (flag_zero_o),
    .flag_neg_o    (flag_neg_o)
);

// File: tb/sim_simd_datapath.sv
module sim_simd_datapath;

    localparam logic [3:0] ADD = 4'd1, SUB = 4'd2, AND_ = 4'd3, OR_ = 4'd4, XOR_ = 4'd5;
    localparam logic [3:0] MUL = 4'd6, SHL = 4'd7, ASR = 4'd8, LD = 4'd9, ST = 4'd10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [20:0] instr_i = '0;
    logic [1:0]  mode_i = 2'b00;
    logic [63:0] ld_data_i = '0;
    logic [1:0]  wb_valid_o;
    logic [63:0] wb_data_o;
    logic        st_valid_o;
    logic        st_wide_o;
    logic [63:0] st_data_o;
    logic [1:0]  flag_zero_o;
    logic [1:0]  flag_neg_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    simd_datapath u0 (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .instr_valid_i (instr_valid_i),
        .instr_i       (instr_i),
        .mode_i        (mode_i),
        .ld_data_i     (ld_data_i),
        .wb_valid_o    (wb_valid_o),
        .wb_data_o     (wb_data_o),
        .st_valid_o    (st_valid_o),
        .st_wide_o     (st_wide_o),
        .st_data_o     (st_data_o),
        .flag_zero_o   (flag_zero_o),
        .flag_neg_o    (flag_neg_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; outputs of the instruction are then visible.
    task automatic issue(input logic [3:0] op, input logic [3:0] d, input logic [3:0] a,
                         input logic [3:0] b, input logic mf, input logic [3:0] md,
                         input logic [63:0] ld);
        instr_i       = {op, d, a, b, mf, md};
        ld_data_i     = ld;
        instr_valid_i = 1'b1;
        @(negedge clk_i);
        instr_valid_i = 1'b0;
        instr_i       = '0;
    endtask

    task automatic op3(input logic [3:0] op, input logic [3:0] d, input logic [3:0] a,
                       input logic [3:0] b);
        issue(op, d, a, b, 1'b0, 4'd0, 64'd0);
    endtask

    task automatic load(input logic [3:0] d, input logic [63:0] ld);
        issue(LD, d, 4'd0, 4'd0, 1'b0, 4'd0, ld);
    endtask

    task automatic store(input logic [3:0] a);
        issue(ST, 4'd0, a, 4'd0, 1'b0, 4'd0, 64'd0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_i = m;
        @(negedge clk_i);
    endtask

    task automatic t_reset;
        chk("R1 wb_valid", {62'd0, wb_valid_o}, 64'd0);
        chk("R1 st_valid/wide", {62'd0, st_valid_o, st_wide_o}, 64'd0);
        chk("R1 flags", {60'd0, flag_zero_o, flag_neg_o}, 64'd0);
        store(4'd3);
        chk("R1 reg reads zero", st_data_o, 64'd0);
        chk("R9 narrow store valid", {62'd0, st_valid_o, st_wide_o}, 64'd2);
    endtask

    task automatic t_alu;
        load(4'd1, 64'hAAAA0000_FFFFFFFF);
        chk("R8 load X word", wb_data_o[31:0], 64'hFFFFFFFF);
        chk("R7 no Y writeback", {62'd0, wb_valid_o}, 64'd1);
        load(4'd2, 64'h00001234_00000002);
        op3(ADD, 4'd3, 4'd1, 4'd2);
        chk("R2 add wraps", wb_data_o[31:0], 64'd1);
        chk("R5 result next cycle", {62'd0, wb_valid_o}, 64'd1);
        op3(SUB, 4'd4, 4'd3, 4'd1);
        chk("R5 back-to-back read", wb_data_o[31:0], 64'd2);
        op3(SUB, 4'd5, 4'd1, 4'd2);
        chk("R2 sub", wb_data_o[31:0], 64'hFFFFFFFD);
        chk("R13 neg flag X", {62'd0, flag_neg_o}, 64'd1);
        op3(AND_, 4'd6, 4'd1, 4'd2);
        chk("R2 and", wb_data_o[31:0], 64'd2);
        op3(OR_, 4'd6, 4'd5, 4'd2);
        chk("R2 or", wb_data_o[31:0], 64'hFFFFFFFF);
        op3(XOR_, 4'd6, 4'd1, 4'd2);
        chk("R2 xor", wb_data_o[31:0], 64'hFFFFFFFD);
        op3(SUB, 4'd0, 4'd2, 4'd2);
        chk("R13 zero flag X", {60'd0, flag_zero_o, flag_neg_o}, 64'h4);
    endtask

    task automatic t_mul;
        load(4'd7, 64'h00000000_FFFFFFFD);
        load(4'd8, 64'd7);
        op3(MUL, 4'd9, 4'd7, 4'd8);
        chk("R3 signed product low", wb_data_o[31:0], 64'hFFFFFFEB);
        chk("R13 mul keeps flags", {60'd0, flag_zero_o, flag_neg_o}, 64'h4);
        load(4'd10, 64'h10000);
        op3(MUL, 4'd11, 4'd10, 4'd10);
        chk("R3 product overflow low zero", wb_data_o[31:0], 64'd0);
        load(4'd12, 64'h7FFFFFFF);
        op3(MUL, 4'd12, 4'd12, 4'd12);
        chk("R3 max square low", wb_data_o[31:0], 64'd1);
    endtask

    task automatic t_shift;
        load(4'd13, 64'd31);
        load(4'd14, 64'd1);
        op3(SHL, 4'd15, 4'd14, 4'd13);
        chk("R4 shl 31", wb_data_o[31:0], 64'h80000000);
        load(4'd13, 64'd4);
        op3(ASR, 4'd15, 4'd15, 4'd13);
        chk("R4 asr sign fill", wb_data_o[31:0], 64'hF8000000);
        load(4'd13, 64'h24);
        op3(SHL, 4'd15, 4'd14, 4'd13);
        chk("R4 amount low five bits", wb_data_o[31:0], 64'h10);
        chk("R13 shift keeps flags", {60'd0, flag_zero_o, flag_neg_o}, 64'h4);
    endtask

    task automatic t_y_untouched;
        set_mode(2'b01);
        store(4'd1);
        chk("R8 upper ignored while Y off", st_data_o, 64'h00000000_FFFFFFFF);
        chk("R9 wide store", {63'd0, st_wide_o}, 64'd1);
        chk("R7 Y flags untouched", {60'd0, flag_zero_o, flag_neg_o}, 64'h4);
    endtask

    task automatic t_dual;
        load(4'd1, 64'h0000000A_00000014);
        chk("R8 dual load", wb_data_o, 64'h0000000A_00000014);
        chk("R6 both lanes write", {62'd0, wb_valid_o}, 64'd3);
        load(4'd2, 64'h00000003_00000004);
        op3(ADD, 4'd3, 4'd1, 4'd2);
        chk("R6 own operands", wb_data_o, 64'h0000000D_00000018);
        store(4'd3);
        chk("R9 two-word store", st_data_o, 64'h0000000D_00000018);
        op3(SUB, 4'd0, 4'd1, 4'd1);
        chk("R13 zero both lanes", {60'd0, flag_zero_o, flag_neg_o}, 64'hC);
        load(4'd5, 64'hFFFFFFFF_00000001);
        op3(ADD, 4'd6, 4'd5, 4'd5);
        chk("R6 dual add", wb_data_o, 64'hFFFFFFFE_00000002);
        chk("R13 neg Y only", {60'd0, flag_zero_o, flag_neg_o}, 64'h2);
    endtask

    task automatic t_multi;
        issue(ADD, 4'd7, 4'd1, 4'd2, 1'b1, 4'd8, 64'd0);
        chk("R10 alu part", wb_data_o, 64'h0000000D_00000018);
        store(4'd8);
        chk("R10 product to second dest", st_data_o, 64'h0000001E_00000050);
        issue(SUB, 4'd9, 4'd1, 4'd2, 1'b1, 4'd9, 64'd0);
        chk("R10 alu part sub", wb_data_o, 64'h00000007_00000010);
        store(4'd9);
        chk("R10 product wins clash", st_data_o, 64'h0000001E_00000050);
    endtask

    task automatic t_y_off_flags;
        op3(ADD, 4'd6, 4'd5, 4'd5);
        set_mode(2'b00);
        op3(SUB, 4'd0, 4'd1, 4'd1);
        chk("R7 Y flags hold", {60'd0, flag_zero_o, flag_neg_o}, 64'h6);
        load(4'd3, 64'h00000309_00000005);
        chk("R7 Y no wb", {62'd0, wb_valid_o}, 64'd1);
        set_mode(2'b01);
        store(4'd3);
        chk("R7 Y reg unchanged", st_data_o, 64'h0000000D_00000005);
    endtask

    task automatic t_bank;
        set_mode(2'b11);
        store(4'd3);
        chk("R11 secondary empty", st_data_o, 64'd0);
        load(4'd3, 64'h00000066_00000055);
        set_mode(2'b01);
        store(4'd3);
        chk("R11 primary intact", st_data_o, 64'h0000000D_00000005);
        set_mode(2'b11);
        store(4'd3);
        chk("R11 secondary holds", st_data_o, 64'h00000066_00000055);
    endtask

    task automatic t_mode_timing;
        set_mode(2'b00);
        mode_i = 2'b01;
        load(4'd4, 64'h00000099_00000011);
        chk("R12 same-cycle uses old mode", {62'd0, wb_valid_o}, 64'd1);
        store(4'd4);
        chk("R12 next uses new mode", {st_wide_o, st_data_o[62:0]}, {1'b1, 63'h11});
        chk("R12 Y reg not loaded", st_data_o[63:32], 64'd0);
        mode_i = 2'b11;
        store(4'd4);
        chk("R12 bank change delayed", st_data_o, 64'h11);
        store(4'd4);
        chk("R12 bank change applied", st_data_o, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_alu();
        t_mul();
        t_shift();
        t_y_untouched();
        t_dual();
        t_multi();
        t_y_off_flags();
        t_bank();
        t_mode_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule